// File: doc/BRIEF.md
# Parallel Display Bus Controller

This block drives a 16-bit parallel command/data bus that can serve up to two external display controllers, each with a chip-select line of its own. Software programs it through a small word-indexed register file. A command write, a parameter write, a 32-bit pixel-pair write and two kinds of bus read each start one bus access. The access holds the chip select and produces one write or read strobe for a fixed number of cycles. Read results land in a receive register that software reads back.

A pixel counter measures the length of a frame transfer. Each pixel write and each bus read counts it down by one. A transfer is started by writing the control register with its start bit set, provided the block is enabled, is not in bypass mode, is not already busy, the upstream display engine has its output enabled, and the two configuration registers do not both have their mode bits 3:2 set. When the counter reaches zero during a transfer, the busy flag drops and a one-cycle done pulse goes to the display engine's interrupt logic. A set of timing, data-cycle, sync and configuration registers is stored and read back with fixed masks. It does not shape the bus waveform.

Register indices on `reg_idx`: 0 control, 1 status, 2 pixel counter, 3 line skip, 4 command, 5 parameter, 6 pixel data, 7 data-phase read, 8 command-phase read, 9 system config, 10 vertical sync, 11 horizontal sync, 12 and 13 configuration A/B, 14 to 17 timing (first word and second word of set 0, then of set 1), 18 to 23 data-cycle words 0 to 5. Unlisted indices read 0.

Top module: `lpb_ctrl`

## Requirements
- R1: After reset, control reads 0x2, both configuration registers read 0x00310000, status reads 0x1, and the pixel counter, line skip and system config read 0. `reg_ready` is high and `frame_done` is low.
- R2: Stored registers read back their write value ANDed with a fixed mask: control 0xF, configuration 0x003F1FFF, the first timing word of a set 0x3FFFFFFF, the second 0x0FFFFFFF, data-cycle 0x0F1F0F1F, line skip 0x7FF, sync 0xFFFF, system config 0x19. The pixel counter keeps all 32 bits, and status ignores writes.
- R3: In control, bit 2 selects chip 0 (`bus_cs[0]`) and bit 3 selects chip 1 (`bus_cs[1]`). A command write makes one write strobe with `bus_dc`=0 and `bus_dout` equal to write bits 15:0, on every selected chip at once. A parameter write does the same with `bus_dc`=1. With no chip selected, no strobe occurs.
- R4: A pixel-data write makes two write strobes with `bus_dc`=1, first carrying bits 15:0 and then bits 31:16, and decrements the pixel counter by one.
- R5: A data-phase read (index 7, `bus_dc`=1) or command-phase read (index 8, `bus_dc`=0) makes one read strobe on chip 0 if it is selected, else on chip 1. It latches `bus_din` into the receive register (read at index 7 or 8) and decrements the pixel counter.
- R6: Every strobe lasts STROBE_CYC cycles with the chip select held. The two strobes of a pixel write are separated by one idle cycle. `reg_ready` is low from the accepted write until the access ends, and a register write offered while it is low has no effect.
- R7: Writing control with bit 4 set starts a transfer (status bit 8 set) only if the new value has bit 0 = 1 and bit 1 = 0, the block is not busy, `disp_out_en` is 1, and bits 3:2 of configuration A and B ANDed together are zero. Otherwise the request is ignored.
- R8: When a pixel write or bus read brings the counter from 1 to 0 during a transfer, busy clears and `frame_done` pulses for one cycle. A start with the counter already at zero pulses `frame_done` without setting busy.
- R9: Writing system config with bit 1 set returns every register to its reset value, and system config then holds the written value ANDed with 0x19.
- R10: Decrementing a zero pixel counter wraps it to 0xFFFFFFFF without raising `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write request, taken on a cycle where `reg_ready` is high |
| reg_idx | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_idx` (combinational) |
| reg_ready | output | 1 | High when no bus access is in progress |
| disp_out_en | input | 1 | Output-enable state of the upstream display engine |
| frame_done | output | 1 | One-cycle pulse at the end of a frame transfer |
| bus_cs | output | 2 | Chip selects, active high, bit n for chip n |
| bus_dc | output | 1 | Data/command line: 1 data or parameter, 0 command |
| bus_wr | output | 1 | Write strobe, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data |

## Verification
On every cycle, assertions check that write and read strobes never overlap and never occur without a chip select or while `reg_ready` is high. They also check that a read touches exactly one chip, that the pixel counter changes only on an accepted write, that a transfer begins only with enable set and bypass clear, and that the fall of busy comes with the done pulse. The bench scenarios show the behaviour that depends on data and order: the low-half-first order of pixel writes, the chip-0 priority on reads, the latched read value, each condition that vetoes a start, the zero-count start, counter wrap, soft reset, and a write held off by the stall.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    localparam int IDX_W     = 5;
    localparam int BANK_BASE = 12;
    localparam int BANK_N    = 12;

    localparam logic [IDX_W-1:0] IX_CTRL   = 5'd0;
    localparam logic [IDX_W-1:0] IX_STAT   = 5'd1;
    localparam logic [IDX_W-1:0] IX_PIX    = 5'd2;
    localparam logic [IDX_W-1:0] IX_SKIP   = 5'd3;
    localparam logic [IDX_W-1:0] IX_CMD    = 5'd4;
    localparam logic [IDX_W-1:0] IX_PARAM  = 5'd5;
    localparam logic [IDX_W-1:0] IX_DATA   = 5'd6;
    localparam logic [IDX_W-1:0] IX_RDDAT  = 5'd7;
    localparam logic [IDX_W-1:0] IX_RDCMD  = 5'd8;
    localparam logic [IDX_W-1:0] IX_SYS    = 5'd9;
    localparam logic [IDX_W-1:0] IX_VSYNC  = 5'd10;
    localparam logic [IDX_W-1:0] IX_HSYNC  = 5'd11;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_GAP    = 2'd2
    } seq_st_e;

    // bank slot k: 0..1 configuration, 2..5 timing pairs, 6..11 data-cycle words
    function automatic logic [31:0] bank_mask(input int k);
        if (k < 2)           return 32'h003F_1FFF;
        else if (k < 6)      return (k % 2 == 0) ? 32'h3FFF_FFFF : 32'h0FFF_FFFF;
        else                 return 32'h0F1F_0F1F;
    endfunction

    function automatic logic [31:0] bank_init(input int k);
        return (k < 2) ? 32'h0031_0000 : 32'h0;
    endfunction

endpackage

// File: rtl/lpb_cfgbank.sv
module lpb_cfgbank #(
    parameter int N_REGS = 12,
    parameter int DW     = 32,
    localparam int KW    = $clog2(N_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [KW-1:0]             wr_k,
    input  logic [DW-1:0]             wdata,
    output logic [N_REGS-1:0][DW-1:0] vals
);
    import lpb_pkg::*;

    for (genvar k = 0; k < N_REGS; k++) begin : g_slot
        localparam logic [DW-1:0] MASK = DW'(bank_mask(k));
        localparam logic [DW-1:0] INIT = DW'(bank_init(k));
        logic [DW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (clr)
                val_d = INIT;
            else if (wr_en && wr_k == KW'(k))
                val_d = wdata & MASK;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= INIT;
            else        val_q <= val_d;
        end

        assign vals[k] = val_q;
    end

endmodule

// File: rtl/lpb_seq.sv
module lpb_seq #(
    parameter int STROBE_CYC = 3,
    localparam int CNT_W     = $clog2(STROBE_CYC + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        go_rd,
    input  logic        go_dc,
    input  logic [1:0]  go_cs,
    input  logic        go_two,
    input  logic [31:0] go_data,
    output logic        idle,
    output logic [15:0] rx_data,
    output logic [1:0]  bus_cs,
    output logic        bus_dc,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [15:0] bus_dout,
    input  logic [15:0] bus_din
);
    import lpb_pkg::*;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             beat;
        logic             rd;
        logic             dc;
        logic [1:0]       cs;
        logic             two;
        logic [31:0]      data;
        logic [15:0]      rx;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            SQ_IDLE: begin
                if (go) begin
                    d.st   = SQ_STROBE;
                    d.cnt  = '0;
                    d.beat = 1'b0;
                    d.rd   = go_rd;
                    d.dc   = go_dc;
                    d.cs   = go_cs;
                    d.two  = go_two;
                    d.data = go_data;
                end
            end
            SQ_STROBE: begin
                if (q.cnt == CNT_W'(STROBE_CYC - 1)) begin
                    if (q.rd) d.rx = bus_din;
                    if (q.two && !q.beat) begin
                        d.st   = SQ_GAP;
                        d.beat = 1'b1;
                    end else begin
                        d.st = SQ_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_GAP: begin
                d.st  = SQ_STROBE;
                d.cnt = '0;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle     = (q.st == SQ_IDLE);
    assign rx_data  = q.rx;
    assign bus_cs   = idle ? 2'b00 : q.cs;
    assign bus_dc   = idle ? 1'b0 : q.dc;
    assign bus_wr   = (q.st == SQ_STROBE) && !q.rd;
    assign bus_rd   = (q.st == SQ_STROBE) && q.rd;
    assign bus_dout = q.rd ? 16'h0 : (q.beat ? q.data[31:16] : q.data[15:0]);

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    p_strobe_has_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> (bus_cs != 2'b00));
    p_read_one_chip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> $onehot(bus_cs));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!bus_wr && !bus_rd && bus_cs == 2'b00));

endmodule

// File: rtl/lpb_ctrl.sv
module lpb_ctrl #(
    parameter int STROBE_CYC = 3,
    parameter int PIX_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_ready,
    input  logic        disp_out_en,
    output logic        frame_done,
    output logic [1:0]  bus_cs,
    output logic        bus_dc,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [15:0] bus_dout,
    input  logic [15:0] bus_din
);
    import lpb_pkg::*;

    localparam int KW = $clog2(BANK_N);

    typedef struct packed {
        logic [3:0]       ctrl;
        logic [PIX_W-1:0] pix;
        logic [10:0]      skip;
        logic [4:0]       sys;
        logic [15:0]      vs;
        logic [15:0]      hs;
        logic             busy;
        logic             done;
    } ctl_t;

    ctl_t d, q;

    logic                    seq_idle, wr_acc, in_bank, soft_clr, decr;
    logic                    go, go_rd, go_dc, go_two;
    logic [1:0]              go_cs, wr_cs, rd_cs;
    logic [15:0]             rx_data;
    logic [BANK_N-1:0][31:0] bank;
    logic [KW-1:0]           bank_k;
    logic                    cfg_ok;

    assign wr_acc   = reg_wr && seq_idle;
    assign in_bank  = (reg_idx >= 5'(BANK_BASE)) && (reg_idx < 5'(BANK_BASE + BANK_N));
    assign bank_k   = KW'(reg_idx - 5'(BANK_BASE));
    assign soft_clr = wr_acc && reg_idx == IX_SYS && reg_wdata[1];
    assign cfg_ok   = ((bank[0][3:2] & bank[1][3:2]) == 2'b00);
    assign wr_cs    = q.ctrl[3:2];
    assign rd_cs    = q.ctrl[2] ? 2'b01 : (q.ctrl[3] ? 2'b10 : 2'b00);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        go     = 1'b0;
        go_rd  = 1'b0;
        go_dc  = 1'b0;
        go_two = 1'b0;
        go_cs  = 2'b00;
        decr   = 1'b0;
        if (wr_acc) begin
            case (reg_idx)
                IX_CTRL: begin
                    d.ctrl = reg_wdata[3:0];
                    if (reg_wdata[4] && cfg_ok && reg_wdata[0] && !reg_wdata[1]
                        && !q.busy && disp_out_en) begin
                        if (q.pix == '0) d.done = 1'b1;
                        else             d.busy = 1'b1;
                    end
                end
                IX_PIX:   d.pix  = reg_wdata[PIX_W-1:0];
                IX_SKIP:  d.skip = reg_wdata[10:0];
                IX_VSYNC: d.vs   = reg_wdata[15:0];
                IX_HSYNC: d.hs   = reg_wdata[15:0];
                IX_SYS: begin
                    if (reg_wdata[1]) begin
                        d.ctrl = 4'h2;
                        d.pix  = '0;
                        d.skip = '0;
                        d.vs   = '0;
                        d.hs   = '0;
                        d.busy = 1'b0;
                    end
                    d.sys = {reg_wdata[4:3], 2'b00, reg_wdata[0]};
                end
                IX_CMD, IX_PARAM, IX_DATA: begin
                    go     = (wr_cs != 2'b00);
                    go_cs  = wr_cs;
                    go_dc  = (reg_idx != IX_CMD);
                    go_two = (reg_idx == IX_DATA);
                    decr   = (reg_idx == IX_DATA);
                end
                IX_RDDAT, IX_RDCMD: begin
                    go    = (rd_cs != 2'b00);
                    go_cs = rd_cs;
                    go_rd = 1'b1;
                    go_dc = (reg_idx == IX_RDDAT);
                    decr  = 1'b1;
                end
                default: ;
            endcase
        end
        if (decr) begin
            d.pix = q.pix - 1'b1;
            if (q.pix == PIX_W'(1) && q.busy) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= 4'h2;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = 32'h0;
        case (reg_idx)
            IX_CTRL:            reg_rdata = {28'h0, q.ctrl};
            IX_STAT:            reg_rdata = {23'h0, q.busy, 8'h01};
            IX_PIX:             reg_rdata = 32'(q.pix);
            IX_SKIP:            reg_rdata = {21'h0, q.skip};
            IX_RDDAT, IX_RDCMD: reg_rdata = {16'h0, rx_data};
            IX_SYS:             reg_rdata = {27'h0, q.sys};
            IX_VSYNC:           reg_rdata = {16'h0, q.vs};
            IX_HSYNC:           reg_rdata = {16'h0, q.hs};
            default:            if (in_bank) reg_rdata = bank[bank_k];
        endcase
    end

    lpb_cfgbank #(.N_REGS(BANK_N), .DW(32)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_clr),
        .wr_en (wr_acc && in_bank),
        .wr_k  (bank_k),
        .wdata (reg_wdata),
        .vals  (bank)
    );

    lpb_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_rd    (go_rd),
        .go_dc    (go_dc),
        .go_cs    (go_cs),
        .go_two   (go_two),
        .go_data  (reg_wdata),
        .idle     (seq_idle),
        .rx_data  (rx_data),
        .bus_cs   (bus_cs),
        .bus_dc   (bus_dc),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_dout (bus_dout),
        .bus_din  (bus_din)
    );

    assign reg_ready  = seq_idle;
    assign frame_done = q.done;

    p_pix_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_ready) |=> $stable(q.pix));
    p_start_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> (q.ctrl[0] && !q.ctrl[1]));
    p_end_pulses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) && !$past(soft_clr) |-> frame_done);

endmodule

// File: tb/lpb_ctrl_bench.sv
module lpb_ctrl_bench;

    localparam int STROBE_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        disp_out_en = 1'b0;
    logic        frame_done;
    logic [1:0]  bus_cs;
    logic        bus_dc, bus_wr, bus_rd;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lpb_ctrl #(.STROBE_CYC(STROBE_CYC)) u_lpb_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .disp_out_en(disp_out_en), .frame_done(frame_done), .bus_cs(bus_cs),
        .bus_dc(bus_dc), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dout(bus_dout),
        .bus_din(bus_din)
    );

    // bus monitor: logs each rising strobe, sampled on the falling clock edge
    logic [18:0] wlog [32];
    logic [2:0]  rlog [32];
    int wn = 0, rn = 0, run_len = 0, last_len = 0;
    logic wr_prev = 1'b0, rd_prev = 1'b0;

    always @(negedge clk) begin
        if (bus_wr && !wr_prev && wn < 32) begin
            wlog[wn] = {bus_cs, bus_dc, bus_dout};
            wn++;
        end
        if (bus_rd && !rd_prev && rn < 32) begin
            rlog[rn] = {bus_cs, bus_dc};
            rn++;
        end
        if (bus_wr || bus_rd) run_len++;
        else if (wr_prev || rd_prev) begin
            last_len = run_len;
            run_len  = 0;
        end
        wr_prev = bus_wr;
        rd_prev = bus_rd;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] val);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_idx   = idx;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (!reg_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] val);
        reg_idx = idx;
        #1;
        val = reg_rdata;
    endtask

    typedef struct packed {
        logic [4:0]  idx;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{5'd12, 32'hFFFF_FFFF, 32'h003F_1FFF},
        '{5'd13, 32'hFFFF_FFF3, 32'h003F_1FF3},
        '{5'd14, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
        '{5'd15, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
        '{5'd16, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
        '{5'd17, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
        '{5'd18, 32'hFFFF_FFFF, 32'h0F1F_0F1F},
        '{5'd23, 32'h1234_5678, 32'h0214_0618},
        '{5'd3,  32'hFFFF_FFFF, 32'h0000_07FF},
        '{5'd10, 32'hFFFF_FFFF, 32'h0000_FFFF},
        '{5'd11, 32'hABCD_1234, 32'h0000_1234},
        '{5'd9,  32'hFFFF_FFFD, 32'h0000_0019},
        '{5'd0,  32'hFFFF_FFE0, 32'h0000_0000},
        '{5'd1,  32'hFFFF_FFFF, 32'h0000_0001}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd0, v);  check("R1 ctrl", v, 32'h2);
        rd(5'd12, v); check("R1 cfgA", v, 32'h0031_0000);
        rd(5'd13, v); check("R1 cfgB", v, 32'h0031_0000);
        rd(5'd1, v);  check("R1 status", v, 32'h1);
        rd(5'd2, v);  check("R1 pix", v, 32'h0);
        rd(5'd9, v);  check("R1 sys", v, 32'h0);
        check("R1 ready", {31'h0, reg_ready}, 32'h1);
        check("R1 done", {31'h0, frame_done}, 32'h0);

        // R2 mask table
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].idx, VECS[i].wd);
            rd(VECS[i].idx, v);
            check("R2 mask", v, VECS[i].exp);
        end
        wr(5'd2, 32'hDEAD_BEEF);
        rd(5'd2, v); check("R2 pix full width", v, 32'hDEAD_BEEF);

        // R9 soft reset
        wr(5'd9, 32'h0000_001B);
        rd(5'd12, v); check("R9 cfgA", v, 32'h0031_0000);
        rd(5'd14, v); check("R9 timing", v, 32'h0);
        rd(5'd2, v);  check("R9 pix", v, 32'h0);
        rd(5'd0, v);  check("R9 ctrl", v, 32'h2);
        rd(5'd3, v);  check("R9 skip", v, 32'h0);
        rd(5'd9, v);  check("R9 sys", v, 32'h19);

        // R3 command / parameter writes
        wr(5'd0, 32'h4);
        w0 = wn;
        wr(5'd4, 32'h1234_5ABC);
        wait_idle();
        check("R3 cmd count", 32'(wn - w0), 32'd1);
        check("R3 cmd beat", 32'(wlog[w0]), {13'h0, 2'b01, 1'b0, 16'h5ABC});
        check("R6 strobe len", 32'(last_len), 32'(STROBE_CYC));
        wr(5'd0, 32'hC);
        w0 = wn;
        wr(5'd5, 32'h0000_00A5);
        wait_idle();
        check("R3 param beat", 32'(wlog[w0]), {13'h0, 2'b11, 1'b1, 16'h00A5});
        wr(5'd0, 32'h0);
        w0 = wn;
        wr(5'd4, 32'h0000_7777);
        wait_idle();
        check("R3 no chip no strobe", 32'(wn - w0), 32'd0);

        // R4 / R6 pixel write and stall
        wr(5'd0, 32'h4);
        wr(5'd2, 32'd10);
        w0 = wn;
        wr(5'd6, 32'hCAFE_1357);
        check("R6 ready low", {31'h0, reg_ready}, 32'h0);
        reg_idx = 5'd2; reg_wdata = 32'h55; reg_wr = 1'b1;
        @(negedge clk); @(negedge clk);
        reg_wr = 1'b0;
        wait_idle();
        rd(5'd2, v); check("R6 stalled write dropped / R4 dec", v, 32'd9);
        check("R4 beats", 32'(wn - w0), 32'd2);
        check("R4 low half first", 32'(wlog[w0]), {13'h0, 2'b01, 1'b1, 16'h1357});
        check("R4 high half second", 32'(wlog[w0+1]), {13'h0, 2'b01, 1'b1, 16'hCAFE});

        // R5 reads
        wr(5'd0, 32'hC);
        bus_din = 16'hBEEF;
        w0 = rn;
        wr(5'd7, 32'h0);
        wait_idle();
        check("R5 read chip0 priority", 32'(rlog[w0]), {29'h0, 2'b01, 1'b1});
        rd(5'd7, v); check("R5 rx data", v, 32'h0000_BEEF);
        rd(5'd2, v); check("R5 pix dec", v, 32'd8);
        wr(5'd0, 32'h8);
        bus_din = 16'h1357;
        w0 = rn;
        wr(5'd8, 32'h0);
        wait_idle();
        check("R5 cmd read chip1", 32'(rlog[w0]), {29'h0, 2'b10, 1'b0});
        rd(5'd8, v); check("R5 rx cmd", v, 32'h0000_1357);

        // R7 start vetoes
        wr(5'd2, 32'd2);
        disp_out_en = 1'b1;
        wr(5'd12, 32'hC); wr(5'd13, 32'hC);
        wr(5'd0, 32'h15);
        rd(5'd1, v); check("R7 cfg veto", v, 32'h1);
        wr(5'd13, 32'h0);
        disp_out_en = 1'b0;
        wr(5'd0, 32'h15);
        rd(5'd1, v); check("R7 out_en veto", v, 32'h1);
        disp_out_en = 1'b1;
        wr(5'd0, 32'h17);
        rd(5'd1, v); check("R7 bypass veto", v, 32'h1);
        wr(5'd0, 32'h14);
        rd(5'd1, v); check("R7 enable veto", v, 32'h1);
        wr(5'd0, 32'h15);
        rd(5'd1, v); check("R7 start busy", v, 32'h101);

        // R8 end of transfer
        wr(5'd6, 32'h0001_0002);
        check("R8 no early done", {31'h0, frame_done}, 32'h0);
        rd(5'd1, v); check("R8 still busy", v, 32'h101);
        wr(5'd6, 32'h0003_0004);
        check("R8 done pulse", {31'h0, frame_done}, 32'h1);
        @(negedge clk);
        check("R8 pulse one cycle", {31'h0, frame_done}, 32'h0);
        rd(5'd1, v); check("R8 busy clear", v, 32'h1);
        wait_idle();
        wr(5'd0, 32'h11);
        check("R8 zero-count start", {31'h0, frame_done}, 32'h1);
        rd(5'd1, v); check("R8 zero-count not busy", v, 32'h1);

        // R10 wrap
        w0 = wn;
        wr(5'd6, 32'h1111_2222);
        check("R10 no done on wrap", {31'h0, frame_done}, 32'h0);
        rd(5'd2, v); check("R10 wrap", v, 32'hFFFF_FFFF);
        check("R3 no chip pixel write", 32'(wn - w0), 32'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule